// File: doc/BRIEF.md
# Interrupt Pending and Forwarding Register

This block holds a vector of pending interrupt flags, one per source, that are raised by writing ones. Two agents can raise flags: software on a small memory-mapped register bus, and a peer on the far end of a serial link, through a dedicated set port. Writing a zero never lowers a flag. A routing control input chooses where the pending flags go.

With routing set to remote, any raised flag makes the block offer an interrupt packet on a valid/ready port. The packet carries a snapshot of the pending vector taken when the offer starts. When the packet is accepted, exactly the snapshot's bits are lowered. A flag raised in the acceptance cycle stays up and is offered in a later packet. With routing set to local, the packet port stays quiet. A level interrupt output shows whether any flag is up, and software lowers flags through an acknowledge port.

An interrupt pointer register sits beside the pending register. It stores a word-aligned address, and its two low bits always read as zero. Software normally loads it with the pending register's own offset, 14h.

Top module: `intr_pend_fwd`

## Requirements
- R1: After reset the pending vector and the pointer read 0, pkt_valid is 0 and irq_out is 0.
- R2: A bus write with bus_we=1 to offset 14h sets every pending bit whose wdata bit is 1. Bits written as 0 keep their value. A read at offset 14h returns the pending vector.
- R3: When peer_set_valid is 1 in a cycle, every pending bit whose peer_set_bits bit is 1 is set.
- R4: With route_local=0, no offer open and a nonzero pending vector at a clock edge, pkt_valid is 1 after that edge and pkt_bits equals the pending vector sampled at that edge. irq_out stays 0.
- R5: While pkt_valid=1 and pkt_ready=0, pkt_valid stays 1 and pkt_bits holds its value.
- R6: At an edge with pkt_valid=1 and pkt_ready=1, the pkt_bits bits are cleared and the offer closes. A bit that is set in that same cycle, by the bus or by the peer, stays 1.
- R7: With route_local=1, irq_out is 1 exactly when some pending bit is 1, and no new offer starts.
- R8: When ack_valid is 1, the pending bits selected by ack_bits are cleared. A set in the same cycle wins.
- R9: A write to offset 18h stores wdata bits 31..2 in the pointer. Reading offset 18h returns those bits with bits 1..0 as 0. Other offsets read 0.
- R10: Reads have no side effects. Reading the pending register any number of times leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| route_local | input | 1 | 1 routes pending flags to irq_out, 0 routes them to the packet port |
| peer_set_valid | input | 1 | Peer set strobe |
| peer_set_bits | input | 32 | Bits the peer raises |
| ack_valid | input | 1 | Local acknowledge strobe |
| ack_bits | input | 32 | Bits to lower |
| pkt_valid | output | 1 | Interrupt packet offered |
| pkt_ready | input | 1 | Packet accepted |
| pkt_bits | output | 32 | Snapshot carried by the packet |
| irq_out | output | 1 | Level local interrupt |

## Verification
The hardest case to reach is the acceptance edge, where the snapshot clear and a fresh set of a bit already in the snapshot happen together. The bench holds pkt_ready low until an offer is open. It then drives a bus write of a bit inside the snapshot and a bit outside it in the same cycle as the ready pulse. After that edge it reads back the vector and checks that both bits survived and that a second offer carries them. The same same-cycle race is repeated on the acknowledge path in local routing.

// File: rtl/intr_pend_fwd.sv
module intr_pend_fwd #(
  parameter int W        = 32,
  parameter int AW       = 8,
  parameter logic [AW-1:0] PEND_OFS = 8'h14,
  parameter logic [AW-1:0] PTR_OFS  = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          route_local,
  input  logic          peer_set_valid,
  input  logic [W-1:0]  peer_set_bits,
  input  logic          ack_valid,
  input  logic [W-1:0]  ack_bits,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [W-1:0]  pkt_bits,
  output logic          irq_out
);

  logic [W-1:0] pend_q;
  logic [W-1:0] snap_q;
  logic         busy_q;
  logic [W-3:0] ptr_q;

  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic         accept;

  assign accept = busy_q & pkt_ready;
  assign set_v  = ((bus_we && bus_addr == PEND_OFS) ? bus_wdata : '0)
                | (peer_set_valid ? peer_set_bits : '0);
  assign clr_v  = (accept ? snap_q : '0) | (ack_valid ? ack_bits : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      snap_q <= '0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (busy_q) begin
        if (pkt_ready) busy_q <= 1'b0;
      end else if (!route_local && pend_q != '0) begin
        busy_q <= 1'b1;
        snap_q <= pend_q;
      end
      if (bus_we && bus_addr == PTR_OFS) ptr_q <= bus_wdata[W-1:2];
    end
  end

  always_comb begin
    case (bus_addr)
      PEND_OFS: bus_rdata = pend_q;
      PTR_OFS:  bus_rdata = {ptr_q, 2'b00};
      default:  bus_rdata = '0;
    endcase
  end

  assign pkt_valid = busy_q;
  assign pkt_bits  = snap_q;
  assign irq_out   = route_local & (|pend_q);

endmodule

// File: rtl/intr_pend_fwd_chk.sv
module intr_pend_fwd_chk #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] PEND_OFS = 8'h14,
  parameter logic [AW-1:0] PTR_OFS  = 8'h18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          route_local,
  input logic          peer_set_valid,
  input logic          ack_valid,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [W-1:0]  pkt_bits,
  input logic          irq_out,
  input logic [W-1:0]  pend_q
);

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_bits)); // R5

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == PEND_OFS |=> (pend_q & $past(bus_wdata)) == $past(bus_wdata)); // R2

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && !bus_we && !peer_set_valid
      |=> (pend_q & $past(pkt_bits)) == '0); // R6

  AST_IRQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> route_local && pend_q != '0); // R7

  AST_PTR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == PTR_OFS |-> bus_rdata[1:0] == 2'b00); // R9

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q != '0 && !ack_valid && !(pkt_valid && pkt_ready) |=> pend_q != '0); // R8

endmodule

bind intr_pend_fwd intr_pend_fwd_chk #(.W(W), .AW(AW), .PEND_OFS(PEND_OFS), .PTR_OFS(PTR_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .route_local(route_local),
  .peer_set_valid(peer_set_valid), .ack_valid(ack_valid),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_bits(pkt_bits),
  .irq_out(irq_out), .pend_q(pend_q)
);

// File: tb/intr_pend_fwd_tb_top.sv
module intr_pend_fwd_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        route_local = 1;
  logic        peer_set_valid = 0;
  logic [31:0] peer_set_bits = 0;
  logic        ack_valid = 0;
  logic [31:0] ack_bits = 0;
  logic        pkt_valid;
  logic        pkt_ready = 0;
  logic [31:0] pkt_bits;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intr_pend_fwd dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .route_local(route_local),
    .peer_set_valid(peer_set_valid), .peer_set_bits(peer_set_bits),
    .ack_valid(ack_valid), .ack_bits(ack_bits), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_bits(pkt_bits), .irq_out(irq_out)
  );

  localparam logic [7:0] PEND = 8'h14;
  localparam logic [7:0] PTR  = 8'h18;

  // {write data, expected pending after write}, local routing
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_0000, 32'h0000_0001},
    {32'h8000_0000, 32'h8000_0001},
    {32'h0000_00F0, 32'h8000_00F1},
    {32'h0000_0001, 32'h8000_00F1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  logic [31:0] r;

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(PEND, r); chk("R1 pending", r, 0);
    rd(PTR, r);  chk("R1 pointer", r, 0);
    chk("R1 pkt_valid", {31'b0, pkt_valid}, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);

    for (int i = 0; i < 6; i++) begin
      wr(PEND, VEC[i][63:32]);
      rd(PEND, r); chk("R2 table", r, VEC[i][31:0]);
      chk("R7 irq table", {31'b0, irq_out}, {31'b0, VEC[i][31:0] != 0});
      chk("R7 no packet", {31'b0, pkt_valid}, 0);
    end

    repeat (3) @(negedge clk);
    rd(PEND, r); chk("R10 read no side effect", r, 32'h8000_00F1);

    // R8: ack with colliding set
    @(negedge clk);
    ack_valid = 1; ack_bits = 32'h8000_00F1;
    bus_we = 1; bus_addr = PEND; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    ack_valid = 0; bus_we = 0;
    rd(PEND, r); chk("R8 ack set wins", r, 32'h0000_0010);
    chk("R8 irq still up", {31'b0, irq_out}, 1);
    @(negedge clk); ack_valid = 1; ack_bits = 32'h10;
    @(negedge clk); ack_valid = 0;
    chk("R8 irq drops", {31'b0, irq_out}, 0);

    // R3: peer set
    @(negedge clk); peer_set_valid = 1; peer_set_bits = 32'h0000_0A00;
    @(negedge clk); peer_set_valid = 0;
    rd(PEND, r); chk("R3 peer set", r, 32'h0000_0A00);

    // R4/R5: switch to remote routing
    route_local = 0;
    @(negedge clk);
    chk("R4 pkt_valid", {31'b0, pkt_valid}, 1);
    chk("R4 pkt_bits", pkt_bits, 32'h0000_0A00);
    chk("R4 irq low", {31'b0, irq_out}, 0);
    wr(PEND, 32'h0000_0004);
    @(negedge clk);
    chk("R5 held valid", {31'b0, pkt_valid}, 1);
    chk("R5 held bits", pkt_bits, 32'h0000_0A00);

    // R6: accept with a colliding set of bit 9 (in snapshot) and bit 0 (not)
    pkt_ready = 1; bus_we = 1; bus_addr = PEND; bus_wdata = 32'h0000_0201;
    @(negedge clk);
    pkt_ready = 0; bus_we = 0;
    rd(PEND, r); chk("R6 collide keeps", r, 32'h0000_0205);
    chk("R6 offer closed", {31'b0, pkt_valid}, 0);
    @(negedge clk);
    chk("R6 second offer", pkt_bits, 32'h0000_0205);
    pkt_ready = 1;
    @(negedge clk);
    pkt_ready = 0;
    rd(PEND, r); chk("R6 cleared", r, 0);
    @(negedge clk);
    chk("R6 no offer when empty", {31'b0, pkt_valid}, 0);

    // R9: pointer
    wr(PTR, 32'hFFFF_FFFF);
    rd(PTR, r); chk("R9 pointer low bits", r, 32'hFFFF_FFFC);
    wr(PTR, 32'h0000_0014);
    rd(PTR, r); chk("R9 pointer value", r, 32'h0000_0014);
    rd(8'h1C, r); chk("R9 other offset", r, 0);
    rd(PEND, r); chk("R9 pointer write leaves pending", r, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule